// File: doc/BRIEF.md
# PWM Dead-Band Delay Generator

This block sits after the edge-placement stage of a PWM channel. It takes two raw waveforms, A and B, and produces a final pair in which rising edges and falling edges are pushed later by separately programmed numbers of clock cycles. A typical use is driving a half-bridge. The rising-edge path delays the turn-on of the upper switch. The falling-edge path, inverted at the output, delays the turn-on of the lower switch. Together they keep a guard gap between the two switches.

Each delay path counts clock cycles from the edge that starts it. If the opposite edge of the source arrives before the count expires, the count is abandoned and the path output keeps its old level. An input pulse as short as the delay, or shorter, therefore leaves no mark on the output. Edges can never come out in a different order from the one in which they went in. The configuration fields are plain inputs that are read on every clock.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted, both delay path outputs and both bypass registers are low. Final A therefore equals `pol_sel[0]`, and final B equals `pol_sel[1]`.
- R2: `src_sel[0]` picks the source of the rising-edge path: 0 selects raw A and 1 selects raw B. `src_sel[1]` picks the source of the falling-edge path in the same way. The value 2 therefore feeds the rising path from A and the falling path from B.
- R3: With a rising delay D, the rising path output goes high on the clock edge after its source has been sampled high on D+1 consecutive edges. It goes low on the clock edge after the source is sampled low. D may be anything from 0 to 2^DLY_W-1.
- R4: With a falling delay D, the falling path output goes low on the clock edge after its source has been sampled low on D+1 consecutive edges. It goes high on the clock edge after the source is sampled high.
- R5: A high pulse on the rising path source that lasts D samples or fewer produces no rising edge at all on that path output.
- R6: A low gap on the falling path source that lasts D samples or fewer leaves the falling path output high throughout.
- R7: A delay of 0 makes a path output follow its source with exactly one cycle of register latency.
- R8: A path reads its delay value only on the edge that starts a count. A change to the delay value during a count has no effect until the next starting edge.
- R9: If `out_mode[0]` is 1, final A comes from the rising path; if it is 0, final A comes from raw A registered once. If `out_mode[1]` is 1, final B comes from the falling path; if it is 0, final B comes from raw B registered once.
- R10: If `pol_sel[0]` is 1, final A is inverted; if `pol_sel[1]` is 1, final B is inverted. The value 2 gives the active-high complementary pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Raw waveform A |
| in_b | input | 1 | Raw waveform B |
| src_sel | input | 2 | Source selection for the two delay paths |
| pol_sel | input | 2 | Output inversion for A (bit 0) and B (bit 1) |
| out_mode | input | 2 | Delay path enable for A (bit 0) and B (bit 1) |
| rise_dly | input | DLY_W | Rising-edge delay in clocks |
| fall_dly | input | DLY_W | Falling-edge delay in clocks |
| out_a | output | 1 | Final output A |
| out_b | output | 1 | Final output B |

## Verification
The bench builds the block with its default DLY_W of 10. This lets it drive a full 1023-cycle delay as well as the 60-cycle working point. The working point is tested with pulses of 59, 60 and 61 samples, which sit just below, at and just above the swallowing boundary. Small delays of 0 to 7 keep the random runs over every source, output-mode and polarity combination short. They also let many edges fall inside a count, which exercises both cancellation and the rule that a delay is read at the start of a count.

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       pol_sel,
  input  logic [1:0]       out_mode,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             out_a,
  output logic             out_b
);

  localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic rise_src, fall_src;
  logic rise_prev, rise_q, fall_prev, fall_q;
  logic a_q, b_q;
  logic [DLY_W-1:0] rise_cnt, rise_lat, fall_cnt, fall_lat;

  assign rise_src = src_sel[0] ? in_b : in_a;
  assign fall_src = src_sel[1] ? in_b : in_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_prev <= 1'b0;
      rise_q    <= 1'b0;
      rise_cnt  <= '0;
      rise_lat  <= '0;
    end else begin
      rise_prev <= rise_src;
      if (!rise_src) begin
        rise_q   <= 1'b0;
        rise_cnt <= '0;
      end else if (!rise_prev) begin
        rise_lat <= rise_dly;
        rise_cnt <= ONE;
        rise_q   <= (rise_dly == '0);
      end else if (!rise_q) begin
        if (rise_cnt >= rise_lat) rise_q <= 1'b1;
        else rise_cnt <= rise_cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_prev <= 1'b0;
      fall_q    <= 1'b0;
      fall_cnt  <= '0;
      fall_lat  <= '0;
    end else begin
      fall_prev <= fall_src;
      if (fall_src) begin
        fall_q   <= 1'b1;
        fall_cnt <= '0;
      end else if (fall_prev) begin
        fall_lat <= fall_dly;
        fall_cnt <= ONE;
        fall_q   <= (fall_dly != '0);
      end else if (fall_q) begin
        if (fall_cnt >= fall_lat) fall_q <= 1'b0;
        else fall_cnt <= fall_cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  assign out_a = (out_mode[0] ? rise_q : a_q) ^ pol_sel[0];
  assign out_b = (out_mode[1] ? fall_q : b_q) ^ pol_sel[1];

endmodule

module pwm_deadband_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_a,
  input logic       in_b,
  input logic [1:0] pol_sel,
  input logic [1:0] out_mode,
  input logic       out_a,
  input logic       out_b,
  input logic       rise_src,
  input logic       fall_src,
  input logic       rise_q,
  input logic       fall_q
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else live <= 1'b1;

  // R3
  rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $rose(rise_q) |-> $past(rise_src));
  // R3
  rise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_src |=> !rise_q);
  // R4
  fall_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_src |=> fall_q);
  // R4
  fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $fell(fall_q) |-> !$past(fall_src));
  // R9
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && out_mode == 2'b00 && pol_sel == 2'b00 |-> out_a == $past(in_a));
  // R9
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && out_mode == 2'b00 && pol_sel == 2'b00 |-> out_b == $past(in_b));
endmodule

bind pwm_deadband pwm_deadband_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
  .pol_sel(pol_sel), .out_mode(out_mode), .out_a(out_a), .out_b(out_b),
  .rise_src(rise_src), .fall_src(fall_src), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/pwm_deadband_tb.sv
module pwm_deadband_tb;
  localparam int DLY_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0;
  logic [1:0] src_sel = 2'd2, pol_sel = 2'd2, out_mode = 2'd3;
  logic [DLY_W-1:0] rise_dly = 10'd60, fall_dly = 10'd60;
  logic out_a, out_b;

  always #4 clk = ~clk;

  pwm_deadband #(.DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .src_sel(src_sel), .pol_sel(pol_sel), .out_mode(out_mode),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .out_a(out_a), .out_b(out_b)
  );

  int tests = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  int hi_run = 0, lo_run = 1 << 20, rlat = 0, flat = 0;
  bit rprev = 0, fprev = 0, rout = 0, fout = 0, ba = 0, bb = 0;
  int a_rises = 0, b_rises = 0;
  bit pa = 0, pb = 0;

  function automatic bit exp_a();
    return (out_mode[0] ? rout : ba) ^ pol_sel[0];
  endfunction
  function automatic bit exp_b();
    return (out_mode[1] ? fout : bb) ^ pol_sel[1];
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit rx, fx;
    rx = src_sel[0] ? in_b : in_a;
    fx = src_sel[1] ? in_b : in_a;
    if (rx) begin
      if (!rprev) begin rlat = int'(rise_dly); hi_run = 1; end
      else if (hi_run < 2000000) hi_run++;
      rout = (hi_run >= rlat + 1);
    end else begin
      hi_run = 0; rout = 0;
    end
    rprev = rx;
    if (!fx) begin
      if (fprev) begin flat = int'(fall_dly); lo_run = 1; end
      else if (lo_run < 2000000) lo_run++;
      fout = !(lo_run >= flat + 1);
    end else begin
      lo_run = 0; fout = 1;
    end
    fprev = fx;
    ba = in_a; bb = in_b;
  endtask

  task automatic step(input bit a, input bit b);
    in_a = a; in_b = b;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(out_a, exp_a(), "out_a");
    check(out_b, exp_b(), "out_b");
    if (out_a && !pa) a_rises++;
    if (out_b && !pb) b_rises++;
    pa = out_a; pb = out_b;
  endtask

  task automatic hold(input bit a, input bit b, input int n);
    for (int i = 0; i < n; i++) step(a, b);
  endtask

  task automatic rand_run(input int n);
    bit a = 0, b = 0;
    int left = 0;
    for (int i = 0; i < n; i++) begin
      if (left == 0) begin
        a = $urandom_range(0, 1); b = $urandom_range(0, 1);
        left = $urandom_range(1, 12);
      end
      left--;
      step(a, b);
    end
  endtask

  task automatic count_check(input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset values with complementary polarity, then with no inversion
    repeat (3) @(negedge clk);
    tag = "R1";
    check(out_a, 1'b0, "out_a in reset");
    check(out_b, 1'b1, "out_b in reset");
    pol_sel = 2'd1; #1;
    check(out_a, 1'b1, "out_a in reset pol1");
    check(out_b, 1'b0, "out_b in reset pol1");
    pol_sel = 2'd2;
    @(negedge clk); rst_n = 1'b1;
    hold(0, 0, 5);

    // R3 / R4: long pulses on the working point
    tag = "R3"; hold(1, 1, 200);
    tag = "R4"; hold(0, 0, 200);
    tag = "R3"; hold(1, 1, 61); hold(0, 0, 100);

    // R5: high pulses at or below the delay are swallowed
    tag = "R5"; a_rises = 0;
    hold(1, 0, 60); hold(0, 0, 100);
    hold(1, 0, 59); hold(0, 0, 100);
    hold(1, 0, 3);  hold(0, 0, 100);
    count_check(a_rises, 0, "out_a rising edges for short pulses");

    // R6: low gaps at or below the delay keep the falling path high
    tag = "R6";
    hold(0, 1, 100); b_rises = 0;
    hold(0, 0, 60); hold(0, 1, 30);
    hold(0, 0, 30); hold(0, 1, 30);
    count_check(b_rises, 0, "out_b rising edges for short gaps");

    // R3: maximum delay
    tag = "R3"; rise_dly = 10'd1023;
    hold(1, 1, 1030); hold(0, 0, 70);

    // R7: zero delay
    tag = "R7"; rise_dly = 0; fall_dly = 0;
    for (int i = 0; i < 40; i++) step(i[0], i[1]);
    rand_run(200);

    // R8: delay change during a count
    tag = "R8"; rise_dly = 10'd20; fall_dly = 10'd20;
    hold(0, 1, 30);
    step(1, 0); rise_dly = 10'd2; fall_dly = 10'd2;
    hold(1, 0, 25); hold(0, 1, 30);
    rise_dly = 10'd2; fall_dly = 10'd2;
    step(1, 0); rise_dly = 10'd30; fall_dly = 10'd30;
    hold(1, 0, 10); hold(0, 1, 40);

    // R2: source selection, small delays
    rise_dly = 10'd3; fall_dly = 10'd7;
    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      src_sel = s[1:0];
      rand_run(300);
    end
    src_sel = 2'd2;

    // R9: output modes
    tag = "R9";
    for (int m = 0; m < 4; m++) begin
      out_mode = m[1:0];
      pol_sel = 2'd0;
      rand_run(250);
    end

    // R10: polarity selections
    tag = "R10"; out_mode = 2'd3;
    for (int p = 0; p < 4; p++) begin
      pol_sel = p[1:0];
      rand_run(250);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule